// File: doc/BRIEF.md
# Page Table Lookup Unit

This unit translates a virtual address when the translation buffer has no entry for it. It takes a lookup request that carries the virtual address and the current job's page-table base. It adds the base to the virtual page number (address bits [31:14]) to get an entry index. It then reads that 32-bit entry through a single request/response memory port and decodes it.

If the entry marks the page as resident, the unit pulses `done`. With the pulse it gives the physical address, the frame number and the dirty flag, which the translation buffer can load directly. If the page is not resident, the unit pulses `fault` instead and gives the secondary-storage pointer taken from the same location field. Servicing the fault and choosing pages to replace are left to the surrounding system.

Top module: `pt_walk_unit`

## Requirements
- R1: After reset is released, `busy`, `mem_req`, `done` and `fault` are all low.
- R2: `mem_addr` carries the entry index, `(pt_base + req_vaddr[31:14]) mod 2^18`. The index is captured when a request is accepted, and the 18-bit sum wraps.
- R3: A request is accepted in idle when `req_valid` is high at a rising edge. `mem_req` is then high for exactly one cycle, the cycle after acceptance. `busy` is high from that cycle until the result pulse, and it is low during the result pulse.
- R4: A response word is decoded as follows: bit 31 is the valid flag, bit 30 is the dirty flag, and bits [17:0] are the location field.
- R5: When the valid flag is 1, `done` is high for one cycle, the cycle after the response is taken. In that cycle `done_paddr` = {location[9:0], vaddr[13:0]}, `done_frame` = location[9:0] and `done_dirty` = bit 30. Location bits above bit 9 are dropped.
- R6: When the valid flag is 0, `fault` is high for one cycle, the cycle after the response is taken, and `done` stays low. In that cycle `fault_ptr` = location[17:0].
- R7: While `busy` is high, `req_valid` is ignored. No new memory read starts, and the result reflects the address and base captured at acceptance.
- R8: A `mem_rsp_valid` that arrives while no read is outstanding is ignored: no `done` or `fault` follows.
- R9: `done` and `fault` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| pt_base | input | 18 | Page-table base of the current job |
| mem_req | output | 1 | Entry read strobe |
| mem_addr | output | 18 | Entry index being read |
| mem_rsp_valid | input | 1 | Entry word is present |
| mem_rsp_data | input | 32 | Entry word |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | Resident result pulse |
| done_paddr | output | 24 | Physical address |
| done_frame | output | 10 | Primary-memory frame number |
| done_dirty | output | 1 | Dirty flag of the entry |
| fault | output | 1 | Page fault pulse |
| fault_ptr | output | 18 | Secondary-storage pointer |

## Verification
The hardest case to reach from the ports is a new request that arrives while a read is still outstanding. To reach it, the bench holds `req_valid` high through the whole wait with a different address and base. It then checks that no second read strobe appears and that the result still uses the first address.

A response that arrives while idle, and a base-plus-page sum that wraps past 18 bits, are also driven on purpose. The bench varies the response latency from zero to several cycles. It compares `busy`, `mem_req` and the result pulses with its own per-cycle expectations.

// File: rtl/pt_walk_unit.sv
module pt_walk_unit #(
  parameter int VA_W      = 32,
  parameter int VPN_LSB   = 14,
  parameter int IDX_W     = 18,
  parameter int ENTRY_W   = 32,
  parameter int LOC_W     = 18,
  parameter int FRAME_W   = 10,
  parameter int VALID_BIT = 31,
  parameter int DIRTY_BIT = 30,
  localparam int PA_W     = FRAME_W + VPN_LSB
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [IDX_W-1:0]   pt_base,
  output logic               mem_req,
  output logic [IDX_W-1:0]   mem_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               busy,
  output logic               done,
  output logic [PA_W-1:0]    done_paddr,
  output logic [FRAME_W-1:0] done_frame,
  output logic               done_dirty,
  output logic               fault,
  output logic [LOC_W-1:0]   fault_ptr
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;
  st_t st;
  logic [VPN_LSB-1:0] off_q;
  logic [IDX_W-1:0]   idx_q;

  wire accept    = (st == S_IDLE) && req_valid;
  wire take      = (st == S_WAIT) && mem_rsp_valid;
  wire ent_valid = mem_rsp_data[VALID_BIT];
  wire unused_rsp_bits = ^mem_rsp_data;

  assign busy     = (st != S_IDLE);
  assign mem_req  = (st == S_REQ);
  assign mem_addr = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      off_q      <= '0;
      idx_q      <= '0;
      done       <= 1'b0;
      fault      <= 1'b0;
      done_paddr <= '0;
      done_frame <= '0;
      done_dirty <= 1'b0;
      fault_ptr  <= '0;
    end else begin
      done  <= take && ent_valid;
      fault <= take && !ent_valid;
      case (st)
        S_IDLE: if (accept) st <= S_REQ;
        S_REQ:  st <= S_WAIT;
        S_WAIT: if (take) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (accept) begin
        off_q <= req_vaddr[VPN_LSB-1:0];
        idx_q <= pt_base + IDX_W'(req_vaddr[VA_W-1:VPN_LSB]);
      end
      if (take && ent_valid) begin
        done_frame <= mem_rsp_data[FRAME_W-1:0];
        done_paddr <= {mem_rsp_data[FRAME_W-1:0], off_q};
        done_dirty <= mem_rsp_data[DIRTY_BIT];
      end
      if (take && !ent_valid)
        fault_ptr <= mem_rsp_data[LOC_W-1:0];
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!busy && !mem_req && !done && !fault));
  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_idle_on_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> !busy);
  assert_result_follows_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> $past(mem_rsp_valid && busy && !mem_req));
  assert_no_restart_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !mem_req);
  assert_index_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_req) |-> $stable(mem_addr));
  assert_exclusive_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

endmodule

// File: tb/pt_walk_unit_tb.sv
module pt_walk_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [17:0] pt_base = '0;
  logic        mem_req;
  logic [17:0] mem_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        busy, done, done_dirty, fault;
  logic [23:0] done_paddr;
  logic [9:0]  done_frame;
  logic [17:0] fault_ptr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  pt_walk_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .pt_base(pt_base), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .busy(busy),
    .done(done), .done_paddr(done_paddr), .done_frame(done_frame),
    .done_dirty(done_dirty), .fault(fault), .fault_ptr(fault_ptr));

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] va, input logic [17:0] base,
                        input logic [31:0] entry, input int lat, input bit hold_other);
    logic [17:0] idx;
    logic        v;
    idx = 18'(base + va[31:14]);
    v   = entry[31];
    req_valid = 1'b1; req_vaddr = va; pt_base = base;
    @(negedge clk);
    chk("R3", "busy after accept", busy, 1);
    chk("R3", "mem_req strobe", mem_req, 1);
    chk("R2", "mem_addr index", mem_addr, idx);
    if (hold_other) begin
      req_vaddr = va ^ 32'hFFFF_C000;
      pt_base   = base ^ 18'h155;
    end else req_valid = 1'b0;
    for (int i = 0; i <= lat; i++) begin
      @(negedge clk);
      chk("R3", "busy while waiting", busy, 1);
      chk(hold_other ? "R7" : "R3", "no second strobe", mem_req, 0);
      chk("R9", "no early result", {done, fault}, 0);
      if (hold_other) chk("R7", "index held", mem_addr, idx);
      if (i == lat) begin mem_rsp_valid = 1'b1; mem_rsp_data = entry; end
    end
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; req_valid = 1'b0;
    chk("R3", "busy low at result", busy, 0);
    if (v) begin
      chk("R5", "done pulse", done, 1);
      chk("R6", "no fault on valid", fault, 0);
      chk("R5", "physical address", done_paddr, {entry[9:0], va[13:0]});
      chk("R5", "frame", done_frame, entry[9:0]);
      chk("R4", "dirty flag", done_dirty, entry[30]);
    end else begin
      chk("R6", "fault pulse", fault, 1);
      chk("R6", "no done on fault", done, 0);
      chk("R6", "pointer", fault_ptr, entry[17:0]);
    end
    @(negedge clk);
    chk("R5", "result is one cycle", {done, fault}, 0);
    chk(hold_other ? "R7" : "R3", "idle after result", {busy, mem_req}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset outputs", {busy, mem_req, done, fault}, 0);

    lookup(32'h0001_4ABC, 18'h0, 32'h8000_0123, 0, 1'b0);
    lookup(32'h0000_8FFF, 18'h3FFFF, 32'hC000_03FF, 3, 1'b0);
    lookup(32'hFFFF_F001, 18'h00010, 32'h0000_2ABCD, 1, 1'b0);
    lookup(32'h1234_5678, 18'h00ABC, 32'h8003_FC55, 2, 1'b1);
    lookup(32'h0ABC_0003, 18'h01000, 32'h4003_1234, 4, 1'b1);

    mem_rsp_valid = 1'b1; mem_rsp_data = 32'h8000_0077;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    @(negedge clk);
    chk("R8", "stray response ignored", {busy, done, fault}, 0);

    lookup(32'h7777_0000, 18'h2, 32'hE000_0001, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule